// File: doc/BRIEF.md
# Parallel LCD Frame Timing Generator

This block drives a parallel RGB panel from the pixel clock. It produces horizontal sync, vertical sync and a data-enable strobe, and it chooses the colour that leaves on the RGB bus. Horizontal timing is set in pixels within a line. Vertical timing is not set in lines. Sync length and the display window are absolute pixel-clock counts taken from a counter that runs across the whole frame. The frame length is lines times pixels per line.

Software programs the geometry through a simple write-only register port. It then sets the run bit. Pixels arrive from an upstream source together with a flag that says the source has run dry. Outside the active window the border colour is sent. While the source underflows, and when recovery is switched on, a fixed recovery colour replaces the pixel data. Clearing the run bit does not stop the timing at once. The generator finishes the current frame, and the frame-boundary pulse tells software that the stop has taken hold.

Top module: `lcd_frame_timer`

## Requirements
- R1: After reset, sync outputs, data-enable, frame pulse and RGB are all 0, and the generator is stopped.
- R2: While running, a line counter counts 0 up to LINE.period-1 and then wraps. Horizontal sync is active while the counter lies in the range from SKEW up to SKEW+LINE.width-1. LINE stores the period in bits [15:0] and the width in bits [31:16].
- R3: While running, vertical sync is active while the frame counter is below VSLEN. VSLEN is a count of pixel clocks.
- R4: Data-enable is high only when both windows hold at once. The line counter must lie in [HWIN.start, HWIN.end], with the start in bits [15:0] and the end in bits [31:16]. The frame counter must lie in [VSTART, VEND]. Both ends of each window are inclusive.
- R5: Bit 0 of POL inverts horizontal sync (active low). Bit 1 of POL inverts vertical sync.
- R6: When data-enable is low, RGB carries BORDER. Otherwise RGB carries the recovery colour (UFLOW bits [23:0]) when the underflow input is high and UFLOW bit 31 is set. In all other cases RGB carries the pixel input. With bit 31 clear, the underflow input has no effect.
- R7: Setting RUN bit 0 while stopped starts a frame. The frame and line counters both start at 0 on the second clock edge after the write.
- R8: Clearing RUN bit 0 while running takes effect only after the last pixel of the frame, when the frame counter equals FLEN-1. Setting the bit again before that point cancels the stop. A one-cycle frame pulse marks every frame end.
- R9: At every frame end, both counters return to 0. This happens even when the line counter is in the middle of a line.
- R10: Each output is registered. It reflects the counter state and the inputs from the previous clock. Writes address these registers: RUN=0, LINE=1, HWIN=2, FLEN=3, VSLEN=4, VSTART=5, VEND=6, SKEW=7, POL=8, BORDER=9, UFLOW=10. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_in | input | CW | Upstream pixel colour |
| pix_underflow | input | 1 | Upstream source has no pixel |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data-enable |
| lcd_rgb | output | CW | Pixel colour to panel |
| frame_evt | output | 1 | One-cycle frame boundary pulse |

## Verification
The hardest case to reach is a stop request that arrives in the middle of a frame. The bench must see that the timing keeps running to the frame's last pixel and halts only there. It must also see that a run request written back before that point cancels the stop. The stimulus writes the run bit low at a chosen offset inside a running frame, and in a second case re-arms it a few cycles later. A behavioural model predicts every output on every clock. A second geometry uses a frame length that is not a multiple of the line length. This forces the line counter to be cut short at the frame boundary, with both sync polarities inverted and underflow recovery off.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int UF_EN_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    A_RUN    = 4'd0,
    A_LINE   = 4'd1,
    A_HWIN   = 4'd2,
    A_FLEN   = 4'd3,
    A_VSLEN  = 4'd4,
    A_VSTART = 4'd5,
    A_VEND   = 4'd6,
    A_SKEW   = 4'd7,
    A_POL    = 4'd8,
    A_BORDER = 4'd9,
    A_UFLOW  = 4'd10
  } cfg_addr_e;
endpackage

// File: rtl/lcdt_rst_sync.sv
module lcdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      s1_q  <= 1'b1;
      rst_q <= s1_q;
    end
  end
endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [HW-1:0]     h_per,
  output logic [HW-1:0]     h_pw,
  output logic [HW-1:0]     h_start,
  output logic [HW-1:0]     h_end,
  output logic [FW-1:0]     f_per,
  output logic [FW-1:0]     vs_len,
  output logic [FW-1:0]     v_start,
  output logic [FW-1:0]     v_end,
  output logic [HW-1:0]     skew,
  output logic              hs_low,
  output logic              vs_low,
  output logic [CW-1:0]     border,
  output logic              uf_en,
  output logic [CW-1:0]     uf_color
);
  localparam int HI_LSB = DATA_W / 2;

  logic              en_n, hs_low_n, vs_low_n, uf_en_n;
  logic [HW-1:0]     h_per_n, h_pw_n, h_start_n, h_end_n, skew_n;
  logic [FW-1:0]     f_per_n, vs_len_n, v_start_n, v_end_n;
  logic [CW-1:0]     border_n, uf_color_n;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    en_n       = en;
    h_per_n    = h_per;
    h_pw_n     = h_pw;
    h_start_n  = h_start;
    h_end_n    = h_end;
    f_per_n    = f_per;
    vs_len_n   = vs_len;
    v_start_n  = v_start;
    v_end_n    = v_end;
    skew_n     = skew;
    hs_low_n   = hs_low;
    vs_low_n   = vs_low;
    border_n   = border;
    uf_en_n    = uf_en;
    uf_color_n = uf_color;
    if (we) begin
      case (addr)
        A_RUN:    en_n = wdata[0];
        A_LINE: begin
          h_per_n = wdata[HW-1:0];
          h_pw_n  = wdata[HI_LSB+HW-1:HI_LSB];
        end
        A_HWIN: begin
          h_start_n = wdata[HW-1:0];
          h_end_n   = wdata[HI_LSB+HW-1:HI_LSB];
        end
        A_FLEN:   f_per_n   = wdata[FW-1:0];
        A_VSLEN:  vs_len_n  = wdata[FW-1:0];
        A_VSTART: v_start_n = wdata[FW-1:0];
        A_VEND:   v_end_n   = wdata[FW-1:0];
        A_SKEW:   skew_n    = wdata[HW-1:0];
        A_POL: begin
          hs_low_n = wdata[0];
          vs_low_n = wdata[1];
        end
        A_BORDER: border_n = wdata[CW-1:0];
        A_UFLOW: begin
          uf_en_n    = wdata[UF_EN_BIT];
          uf_color_n = wdata[CW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      h_per    <= '0;
      h_pw     <= '0;
      h_start  <= '0;
      h_end    <= '0;
      f_per    <= '0;
      vs_len   <= '0;
      v_start  <= '0;
      v_end    <= '0;
      skew     <= '0;
      hs_low   <= 1'b0;
      vs_low   <= 1'b0;
      border   <= '0;
      uf_en    <= 1'b0;
      uf_color <= '0;
    end else if (we) begin
      en       <= en_n;
      h_per    <= h_per_n;
      h_pw     <= h_pw_n;
      h_start  <= h_start_n;
      h_end    <= h_end_n;
      f_per    <= f_per_n;
      vs_len   <= vs_len_n;
      v_start  <= v_start_n;
      v_end    <= v_end_n;
      skew     <= skew_n;
      hs_low   <= hs_low_n;
      vs_low   <= vs_low_n;
      border   <= border_n;
      uf_en    <= uf_en_n;
      uf_color <= uf_color_n;
    end
  end
endmodule

// File: rtl/lcdt_counters.sv
module lcdt_counters #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] h_per,
  input  logic [FW-1:0] f_per,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          frame_last
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  logic          run_n;
  logic [HW-1:0] hcnt_n;
  logic [FW-1:0] fcnt_n;
  logic          line_end;

  always_comb begin
    frame_last = run && (fcnt == f_per - F_ONE);
    line_end   = (hcnt == h_per - H_ONE);
    run_n      = run;
    hcnt_n     = hcnt;
    fcnt_n     = fcnt;
    if (!run || frame_last) begin
      run_n  = en;
      hcnt_n = '0;
      fcnt_n = '0;
    end else begin
      fcnt_n = fcnt + F_ONE;
      hcnt_n = line_end ? '0 : hcnt + H_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      run  <= run_n;
      hcnt <= hcnt_n;
      fcnt <= fcnt_n;
    end
  end
endmodule

// File: rtl/lcdt_window.sv
module lcdt_window #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic          frame_last,
  input  logic [HW-1:0] h_pw,
  input  logic [HW-1:0] skew,
  input  logic [HW-1:0] h_start,
  input  logic [HW-1:0] h_end,
  input  logic [FW-1:0] vs_len,
  input  logic [FW-1:0] v_start,
  input  logic [FW-1:0] v_end,
  input  logic          hs_low,
  input  logic          vs_low,
  output logic          de_next,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          evt
);
  logic [HW:0] hs_lo, hs_hi, hcnt_x;
  logic        hs_act, vs_act, h_in, v_in;
  logic        hsync_n, vsync_n;

  always_comb begin
    hcnt_x  = {1'b0, hcnt};
    hs_lo   = {1'b0, skew};
    hs_hi   = {1'b0, skew} + {1'b0, h_pw};
    hs_act  = run && (hcnt_x >= hs_lo) && (hcnt_x < hs_hi);
    vs_act  = run && (fcnt < vs_len);
    h_in    = (hcnt >= h_start) && (hcnt <= h_end);
    v_in    = (fcnt >= v_start) && (fcnt <= v_end);
    de_next = run && h_in && v_in;
    hsync_n = hs_act ^ hs_low;
    vsync_n = vs_act ^ vs_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      de    <= 1'b0;
      evt   <= 1'b0;
    end else begin
      hsync <= hsync_n;
      vsync <= vsync_n;
      de    <= de_next;
      evt   <= frame_last;
    end
  end
endmodule

// File: rtl/lcdt_pixmux.sv
module lcdt_pixmux #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_next,
  input  logic [CW-1:0] pix_in,
  input  logic          underflow,
  input  logic          uf_en,
  input  logic [CW-1:0] uf_color,
  input  logic [CW-1:0] border,
  output logic [CW-1:0] rgb
);
  logic [CW-1:0] rgb_n;

  always_comb begin
    if (!de_next)               rgb_n = border;
    else if (underflow && uf_en) rgb_n = uf_color;
    else                        rgb_n = pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb <= '0;
    else        rgb <= rgb_n;
  end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdt_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [CW-1:0]     pix_in,
  input  logic              pix_underflow,
  output logic              lcd_hsync,
  output logic              lcd_vsync,
  output logic              lcd_de,
  output logic [CW-1:0]     lcd_rgb,
  output logic              frame_evt
);
  logic          rst_q;
  logic          en, hs_low, vs_low, uf_en;
  logic [HW-1:0] h_per, h_pw, h_start, h_end, skew;
  logic [FW-1:0] f_per, vs_len, v_start, v_end;
  logic [CW-1:0] border, uf_color;
  logic          run, frame_last, de_next;
  logic [HW-1:0] hcnt;
  logic [FW-1:0] fcnt;

  lcdt_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  lcdt_regs #(.HW(HW), .FW(FW), .CW(CW)) i_regs (
    .clk(clk), .rst_n(rst_q), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .h_per(h_per), .h_pw(h_pw), .h_start(h_start), .h_end(h_end),
    .f_per(f_per), .vs_len(vs_len), .v_start(v_start), .v_end(v_end),
    .skew(skew), .hs_low(hs_low), .vs_low(vs_low), .border(border),
    .uf_en(uf_en), .uf_color(uf_color)
  );

  lcdt_counters #(.HW(HW), .FW(FW)) i_cnt (
    .clk(clk), .rst_n(rst_q), .en(en), .h_per(h_per), .f_per(f_per),
    .run(run), .hcnt(hcnt), .fcnt(fcnt), .frame_last(frame_last)
  );

  lcdt_window #(.HW(HW), .FW(FW)) i_win (
    .clk(clk), .rst_n(rst_q), .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .frame_last(frame_last), .h_pw(h_pw), .skew(skew), .h_start(h_start),
    .h_end(h_end), .vs_len(vs_len), .v_start(v_start), .v_end(v_end),
    .hs_low(hs_low), .vs_low(vs_low), .de_next(de_next),
    .hsync(lcd_hsync), .vsync(lcd_vsync), .de(lcd_de), .evt(frame_evt)
  );

  lcdt_pixmux #(.CW(CW)) i_pix (
    .clk(clk), .rst_n(rst_q), .de_next(de_next), .pix_in(pix_in),
    .underflow(pix_underflow), .uf_en(uf_en), .uf_color(uf_color),
    .border(border), .rgb(lcd_rgb)
  );
endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [HW-1:0] hcnt,
  input logic [FW-1:0] fcnt,
  input logic [FW-1:0] f_per,
  input logic          frame_evt,
  input logic          de
);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  assert_evt_counters_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> (hcnt == '0 && fcnt == '0));

  assert_stop_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(fcnt) == $past(f_per) - F_ONE));

  assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && f_per != F_ONE) |=> !frame_evt);

  assert_idle_no_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !de);

  assert_idle_counters_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0 && fcnt == '0));
endmodule

bind lcd_frame_timer lcd_frame_timer_chk #(.HW(HW), .FW(FW)) i_chk (
  .clk(clk), .rst_n(rst_q), .run(run), .hcnt(hcnt), .fcnt(fcnt),
  .f_per(f_per), .frame_evt(frame_evt), .de(lcd_de)
);

// File: tb/test_lcd_frame_timer.sv
module test_lcd_frame_timer;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [CW-1:0] pix_in = '0;
  logic          pix_underflow = 1'b0;
  logic          lcd_hsync, lcd_vsync, lcd_de, frame_evt;
  logic [CW-1:0] lcd_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit uf_noise = 0;
  string tag = "R1";

  // behavioural model state
  int m_rcnt = 0;
  int m_run = 0, m_en = 0, m_h = 0, m_f = 0;
  int c_hper = 0, c_hpw = 0, c_hs = 0, c_he = 0, c_fper = 0, c_vsl = 0;
  int c_vs = 0, c_ve = 0, c_skew = 0, c_hlow = 0, c_vlow = 0, c_ufen = 0;
  int c_border = 0, c_ufc = 0;
  logic e_hs = 0, e_vs = 0, e_de = 0, e_evt = 0;
  logic [CW-1:0] e_rgb = '0;

  always #5 clk = ~clk;

  lcd_frame_timer i_lcd_frame_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_underflow(pix_underflow),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
    .lcd_rgb(lcd_rgb), .frame_evt(frame_evt)
  );

  always @(posedge clk) begin
    if (!rst_n || m_rcnt < 2) begin
      if (rst_n) m_rcnt++; else m_rcnt = 0;
      m_run = 0; m_en = 0; m_h = 0; m_f = 0;
      c_hper = 0; c_hpw = 0; c_hs = 0; c_he = 0; c_fper = 0; c_vsl = 0;
      c_vs = 0; c_ve = 0; c_skew = 0; c_hlow = 0; c_vlow = 0; c_ufen = 0;
      c_border = 0; c_ufc = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_evt = 0; e_rgb = '0;
    end else begin
      bit act, last;
      act   = m_run != 0 && m_h >= c_skew && m_h < c_skew + c_hpw;
      e_hs  = act ^ (c_hlow != 0);
      act   = m_run != 0 && m_f < c_vsl;
      e_vs  = act ^ (c_vlow != 0);
      e_de  = m_run != 0 && m_h >= c_hs && m_h <= c_he && m_f >= c_vs && m_f <= c_ve;
      if (!e_de) e_rgb = CW'(c_border);
      else if (pix_underflow && c_ufen != 0) e_rgb = CW'(c_ufc);
      else e_rgb = pix_in;
      last  = m_run != 0 && m_f == c_fper - 1;
      e_evt = last;
      if (m_run == 0 || last) begin
        m_run = m_en; m_h = 0; m_f = 0;
      end else begin
        m_f++;
        m_h = (m_h == c_hper - 1) ? 0 : m_h + 1;
      end
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: m_en = int'(cfg_wdata[0]);
          4'd1: begin c_hper = int'(cfg_wdata[11:0]); c_hpw = int'(cfg_wdata[27:16]); end
          4'd2: begin c_hs = int'(cfg_wdata[11:0]); c_he = int'(cfg_wdata[27:16]); end
          4'd3: c_fper = int'(cfg_wdata[23:0]);
          4'd4: c_vsl = int'(cfg_wdata[23:0]);
          4'd5: c_vs = int'(cfg_wdata[23:0]);
          4'd6: c_ve = int'(cfg_wdata[23:0]);
          4'd7: c_skew = int'(cfg_wdata[11:0]);
          4'd8: begin c_hlow = int'(cfg_wdata[0]); c_vlow = int'(cfg_wdata[1]); end
          4'd9: c_border = int'(cfg_wdata[23:0]);
          4'd10: begin c_ufen = int'(cfg_wdata[31]); c_ufc = int'(cfg_wdata[23:0]); end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", req, tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(32'(lcd_hsync), 32'(e_hs), "R2 hsync");
    chk(32'(lcd_vsync), 32'(e_vs), "R3 vsync");
    chk(32'(lcd_de), 32'(e_de), "R4 de");
    chk(32'(lcd_rgb), 32'(e_rgb), "R6 rgb");
    chk(32'(frame_evt), 32'(e_evt), "R8 frame_evt");
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    pix_in = CW'($urandom);
    pix_underflow = uf_noise ? ($urandom % 3 == 0) : 1'b0;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (phase %s) actual=running expected=finished", tag);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(32'(lcd_hsync), 0, "R1 hsync");
    chk(32'(lcd_vsync), 0, "R1 vsync");
    chk(32'(lcd_de), 0, "R1 de");
    chk(32'(lcd_rgb), 0, "R1 rgb");
    chk(32'(frame_evt), 0, "R1 evt");
    run_cycles(3);

    // R10: program geometry A through the register map
    tag = "R10";
    uf_noise = 1;
    wr(4'd1, 32'h0002_000A);
    wr(4'd2, 32'h0008_0003);
    wr(4'd3, 32'd80);
    wr(4'd4, 32'd20);
    wr(4'd5, 32'd31);
    wr(4'd6, 32'd70);
    wr(4'd7, 32'd1);
    wr(4'd9, 32'h0011_2233);
    wr(4'd10, 32'h80AB_CDEF);
    wr(4'd12, 32'hFFFF_FFFF);
    run_cycles(4);

    // R7: start, then R9 across frame boundaries
    tag = "R7";
    wr(4'd0, 32'd1);
    run_cycles(80);
    tag = "R9";
    run_cycles(100);

    // R8: stop requested in mid-frame
    tag = "R8";
    wr(4'd0, 32'd0);
    run_cycles(100);

    // R5: inverted sync, recovery off, frame length not a line multiple
    tag = "R5";
    wr(4'd8, 32'd3);
    wr(4'd10, 32'h0055_6677);
    wr(4'd1, 32'h0003_0007);
    wr(4'd2, 32'h0006_0000);
    wr(4'd7, 32'd0);
    wr(4'd3, 32'd50);
    wr(4'd4, 32'd7);
    wr(4'd5, 32'd7);
    wr(4'd6, 32'd45);
    wr(4'd9, 32'h0000_0F0F);
    wr(4'd0, 32'd1);
    run_cycles(120);

    // R8: stop cancelled before frame end, then a real stop
    tag = "R8";
    wr(4'd0, 32'd0);
    run_cycles(5);
    wr(4'd0, 32'd1);
    run_cycles(60);
    wr(4'd0, 32'd0);
    run_cycles(60);

    // R6: recovery on, normal polarity
    tag = "R6";
    wr(4'd8, 32'd0);
    wr(4'd10, 32'h8012_3456);
    wr(4'd0, 32'd1);
    run_cycles(110);

    done = 1;
    summary();
    $finish;
  end
endmodule